// File: doc/BRIEF.md
# Indirect Statistics Counter Bank

The block keeps a bank of per-port statistics counters (thirty-two by default) next to a MAC. Each counter has its own event input. The MAC pulses that input for one clock whenever the matching condition occurs. Typical events are a frame dropped after too many collisions, a frame sent after a single collision and a frame sent after several collisions. Each pulse adds one to the counter.

A host never addresses a counter directly. It writes a control word made of a table-select code and an index. The block then fetches the selected counter into a 32-bit result register and returns that register as two 16-bit halves. The result word carries a wrap flag, a valid flag and the count. Fetching a counter also clears it, so every read returns the events counted since the previous read.

Top module: `mib_counter_bank`

## Requirements
- R1: After reset every counter is zero, and the result register reads zero in both halves.
- R2: A control write carries a 2-bit table select and a 10-bit index. Select code 2'b11 picks the counter table, and index k (0 to 31) picks counter k. A pulse on event bit k adds one to counter k.
- R3: The result word holds the wrap flag in bit 31, the valid flag in bit 30 and the count, zero-extended, in bits 29:0.
- R4: With the half select at 0, the data output shows bits 15:0 of the result word. With the half select at 1, it shows bits 31:16.
- R5: In the cycle after a control write the result word is all zeros, valid flag included. In the next cycle it holds the fetched copy with the valid flag set.
- R6: A fetch clears the count and the wrap flag of the fetched counter only. All other counters keep their values.
- R7: An event that arrives in the same cycle as the fetch is not part of the value returned. It is counted into the cleared counter, so the next read returns 1.
- R8: When a count wraps from all ones to zero, the wrap flag (bit 31) is set. It stays set, while counting goes on, until the counter is fetched.
- R9: A select code other than 2'b11 returns a word of all zeros and leaves every counter unchanged.
- R10: An index of 32 or above with select 2'b11 returns all zeros and leaves every counter unchanged.
- R11: Once fetched, the result register holds its value until the next control write, even while new events arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | NUM_CNT | One-cycle event pulses, one bit per counter |
| ctrl_we_i | input | 1 | Control-word write strobe |
| ctrl_sel_i | input | 2 | Table select (2'b11 = counter table) |
| ctrl_idx_i | input | 10 | Counter index |
| rd_half_i | input | 1 | Half select: 0 = bits 15:0, 1 = bits 31:16 |
| rdata_o | output | 16 | Selected half of the result word |

## Verification
The assertions assume three things about the inputs. Each event bit is synchronous to the clock. A control write lasts one cycle. The host waits out the single fetch cycle before it reads. The stimulus drives every input on the falling edge, raises the write strobe for exactly one cycle and reads only after the fetch has completed. The only deliberate overlap is the event placed on the fetch edge to exercise R7. The wrap behaviour is checked on a second instance whose counter width is reduced to four bits, so that the wrap is reached within a few pulses.

// File: rtl/mib_pkg.sv
package mib_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned FIELD_W = 30;
  localparam logic [SEL_W-1:0] SEL_MIB = 2'b11;

  typedef struct packed {
    logic               ovf;
    logic               vld;
    logic [FIELD_W-1:0] cnt;
  } mib_word_t;
endpackage

// File: rtl/mib_cnt_cell.sv
module mib_cnt_cell #(
  parameter int unsigned CNT_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= CNT_W'(inc_i);  // same-cycle event survives the clear
      ovf_q <= 1'b0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) ovf_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  assert_wrap_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && (&cnt_q)) |=> (ovf_q && cnt_q == '0));
  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q);
  assert_clear_keeps_event_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!ovf_q && cnt_q == CNT_W'($past(inc_i))));
endmodule

// File: rtl/mib_access_ctrl.sv
module mib_access_ctrl
  import mib_pkg::*;
#(
  parameter int unsigned NUM_CNT = 32,
  parameter int unsigned CNT_W   = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] cnt_i [NUM_CNT],
  input  logic [NUM_CNT-1:0] ovf_i,
  output logic [NUM_CNT-1:0] clr_o,
  output mib_word_t        word_o
);
  localparam int unsigned SLOT_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  logic              pend_q, hit_q;
  logic [SLOT_W-1:0] slot_q;
  mib_word_t         word_q, word_d;
  logic              hit_d;

  assign hit_d = (sel_i == SEL_MIB) && (idx_i < IDX_W'(NUM_CNT));

  always_comb begin
    word_d = '0;
    if (hit_q) begin
      word_d.ovf = ovf_i[slot_q];
      word_d.vld = 1'b1;
      word_d.cnt = FIELD_W'(cnt_i[slot_q]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hit_q  <= 1'b0;
      slot_q <= '0;
      word_q <= '0;
    end else if (we_i) begin
      pend_q <= 1'b1;
      hit_q  <= hit_d;
      slot_q <= idx_i[SLOT_W-1:0];
      word_q <= '0;   // valid drops while the fetch is pending
    end else if (pend_q) begin
      pend_q <= 1'b0;
      word_q <= word_d;
    end
  end

  always_comb begin
    clr_o = '0;
    if (pend_q && hit_q && !we_i) clr_o[slot_q] = 1'b1;
  end

  assign word_o = word_q;

  assert_valid_low_after_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (word_q == '0));
  assert_valid_after_fetch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && hit_q && !we_i) |=> word_q.vld);
  assert_miss_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !hit_q && !we_i) |=> (word_q == '0));
  assert_single_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !pend_q) |=> $stable(word_q));
endmodule

// File: rtl/mib_counter_bank.sv
module mib_counter_bank
  import mib_pkg::*;
#(
  parameter int unsigned NUM_CNT = 32,
  parameter int unsigned CNT_W   = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] event_i,
  input  logic               ctrl_we_i,
  input  logic [1:0]         ctrl_sel_i,
  input  logic [9:0]         ctrl_idx_i,
  input  logic               rd_half_i,
  output logic [15:0]        rdata_o
);
  logic [CNT_W-1:0]   cnt_w [NUM_CNT];
  logic [NUM_CNT-1:0] ovf_w;
  logic [NUM_CNT-1:0] clr_w;
  mib_word_t          word_w;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cell
    mib_cnt_cell #(.CNT_W(CNT_W)) i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (event_i[g]),
      .clr_i  (clr_w[g]),
      .cnt_o  (cnt_w[g]),
      .ovf_o  (ovf_w[g])
    );
  end

  mib_access_ctrl #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_we_i),
    .sel_i  (ctrl_sel_i),
    .idx_i  (ctrl_idx_i),
    .cnt_i  (cnt_w),
    .ovf_i  (ovf_w),
    .clr_o  (clr_w),
    .word_o (word_w)
  );

  assign rdata_o = rd_half_i ? word_w[WORD_W-1:HALF_W] : word_w[HALF_W-1:0];

  assert_no_clear_on_miss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !(ctrl_sel_i == SEL_MIB && ctrl_idx_i < 10'(NUM_CNT))) |=> (clr_w == '0));
endmodule

// File: tb/test_mib_counter_bank.sv
`timescale 1ns/1ps
module test_mib_counter_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ev = '0;
  logic        we = 1'b0;
  logic [1:0]  sel = '0;
  logic [9:0]  idx = '0;
  logic        half = 1'b0;
  logic [15:0] rd, rd_s;

  int checks = 0, fails = 0;
  int mdl [32];
  logic [31:0] last_w, last_s;

  always #4 clk = ~clk;

  mib_counter_bank i_mib_counter_bank (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .ctrl_we_i(we),
    .ctrl_sel_i(sel), .ctrl_idx_i(idx), .rd_half_i(half), .rdata_o(rd));

  mib_counter_bank #(.CNT_W(4)) i_mib_small (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .ctrl_we_i(we),
    .ctrl_sel_i(sel), .ctrl_idx_i(idx), .rd_half_i(half), .rdata_o(rd_s));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic sample(output logic [31:0] w, output logic [31:0] ws);
    half = 1'b0; #1; w[15:0] = rd; ws[15:0] = rd_s;
    half = 1'b1; #1; w[31:16] = rd; ws[31:16] = rd_s;
    half = 1'b0;
  endtask

  task automatic pulse(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ev = '0; ev[k] = 1'b1;
    end
    @(negedge clk); ev = '0;
    mdl[k] += n;
  endtask

  // write control word, check the pending cycle, then fetch and compare
  task automatic read_chk(input logic [1:0] s, input logic [9:0] i, input logic [31:0] emask,
                          input string tag);
    logic [31:0] w, ws, exp;
    logic hit;
    hit = (s == 2'b11) && (i < 32);
    exp = hit ? {2'b01, 30'(mdl[i[4:0]])} : 32'h0;
    @(negedge clk); we = 1'b1; sel = s; idx = i;
    @(negedge clk); we = 1'b0; ev = emask;
    sample(w, ws);
    check("R5 pending word zero", w, 32'h0);
    @(negedge clk); ev = '0;
    sample(w, ws);
    check(tag, w, exp);
    for (int j = 0; j < 32; j++) mdl[j] += int'(emask[j]);
    if (hit) mdl[i[4:0]] = int'(emask[i[4:0]]);
    last_w = w; last_s = ws;
  endtask

  localparam logic [1:0] V_SEL [10] = '{2'b11, 2'b11, 2'b11, 2'b11, 2'b01, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11};
  localparam int         V_IDX [10] = '{0, 7, 31, 16, 3, 3, 40, 8, 12, 12};
  localparam int         V_NUM [10] = '{1, 5, 12, 0, 4, 2, 3, 1, 2, 0};

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w, ws;
    for (int j = 0; j < 32; j++) mdl[j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sample(w, ws);
    check("R1 reset result word", w, 32'h0);
    read_chk(2'b11, 10'd0, '0, "R1 counter zero after reset");

    // table walk: R2 R3 R4 R6 R9 R10
    for (int v = 0; v < 10; v++) begin
      if (V_NUM[v] > 0) pulse(V_IDX[v] % 32, V_NUM[v]);
      read_chk(V_SEL[v], 10'(V_IDX[v]), '0, $sformatf("R2/R3/R4/R6/R9/R10 vector %0d", v));
    end
    read_chk(2'b11, 10'd3, '0, "R9 counter cleared by earlier fetch");

    // R4 halves explicitly: count 0x12345 needs too many pulses; use 0x1_0005? keep small
    pulse(9, 70000 - 69930);
    read_chk(2'b11, 10'd9, '0, "R4 low half count");
    check("R4 high half", {16'h0, last_w[31:16]}, 32'h0000_4000);

    // R7 event in the fetch cycle
    pulse(5, 3);
    read_chk(2'b11, 10'd5, 32'h20, "R7 value excludes fetch-cycle event");
    read_chk(2'b11, 10'd5, '0, "R7 fetch-cycle event counted");

    // R11 hold while events arrive
    pulse(20, 9);
    read_chk(2'b11, 10'd20, '0, "R11 initial fetch");
    pulse(20, 4);
    sample(w, ws);
    check("R11 result held", w, {2'b01, 30'd9});
    read_chk(2'b11, 10'd20, '0, "R11 later fetch");

    // R8 wrap on 4-bit instance
    pulse(2, 16);
    pulse(2, 3);
    read_chk(2'b11, 10'd2, '0, "R8 default instance count");
    check("R8 wrap flag sticky", last_s, 32'hC000_0003);
    read_chk(2'b11, 10'd2, '0, "R8 default after clear");
    check("R8 wrap flag cleared", last_s, 32'h4000_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule